// File: doc/BRIEF.md
# Saturating Multi-Mode Fixed-Point Multiplier

This block multiplies two N-bit operands and returns an N-bit result one clock later. A two-bit mode input sets how the operands are read: as unsigned integers, as signed two's complement integers, or as signed fractions with the binary point just below the sign bit. The same double-width product feeds all three modes. Each mode then takes its own N-bit result from that product.

In the two integer modes, a product that cannot be held in N bits is clamped to the nearest end of the range. In fractional mode, the result is realigned so that it keeps the operands' resolution. The realignment drops the duplicated sign bit at the top of the product and the surplus fraction bits at the bottom, with no rounding. Every product of two fractions fits, except the most negative value times itself. That one case is clamped to the largest positive fraction.

A saturated flag reports each clamp. An output valid tracks the input valid with one cycle of delay, so the block can sit inside a pipelined datapath.

Top module: `fxp_sat_mul`

## Requirements
- R1: Mode 2'b00 (unsigned integer) reads both operands as unsigned, and returns the low N bits of the product whenever the product is at most 2^N-1.
- R2: In mode 2'b00, a product above 2^N-1 returns all ones with the saturated flag set. For example, with N=4, 3 x 8 returns 4'b1111.
- R3: Mode 2'b01 (signed integer) reads both operands as two's complement, and returns the exact product when it lies in [-2^(N-1), 2^(N-1)-1].
- R4: In mode 2'b01, a product above 2^(N-1)-1 returns 2^(N-1)-1, and a product below -2^(N-1) returns -2^(N-1). Both cases set the saturated flag. For example, with N=4, 3 x 1000b returns 4'b1000.
- R5: Mode 2'b10 (signed fraction) returns bits [2N-2:N-1] of the 2N-bit signed product, which truncates toward negative infinity. For example, with N=4, 0110 x 1110 returns 1110, and with N=16, 0x0011 x 0xFE12 returns 0xFFFF.
- R6: In mode 2'b10, the operand pair (-2^(N-1), -2^(N-1)) returns 2^(N-1)-1 with the saturated flag set. No other operand pair sets the flag in this mode.
- R7: The saturated flag is low for every accepted product that fits in its mode's range.
- R8: An operation accepted with in_valid high shows its result, its flag and out_valid high on the next clock edge. A cycle with in_valid low gives out_valid low on the next edge.
- R9: While in_valid is low, out_res and out_sat keep their previous values.
- R10: Mode 2'b11 behaves exactly like mode 2'b00.
- R11: While rst_n is low, out_valid, out_res and out_sat are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| mode | input | 2 | 00 unsigned integer, 01 signed integer, 10 signed fraction, 11 same as 00 |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_res | output | N | Registered result |
| out_sat | output | 1 | The registered result was clamped |

## Verification
The assertions check several properties on every cycle. They check the one-cycle valid timing and the holding of the result while idle. They check that any clamp in the integer modes lands on all ones or on a range end. They check that, in fractional mode, the flag is raised exactly when both operands are the most negative value. They also check that the flag never rises without an overflow in the selection logic. Only the bench's reference model can show that each in-range value is the correct product bits and that the truncation rounds downward. The bench runs directed corner vectors at N=4 and N=16, then random traffic in all four modes.

// File: rtl/fxp_mul_pkg.sv
package fxp_mul_pkg;

  typedef enum logic [1:0] {
    MODE_UINT     = 2'b00,
    MODE_SINT     = 2'b01,
    MODE_QFRAC    = 2'b10,
    MODE_UINT_ALT = 2'b11
  } mul_mode_e;

  // Operands are sign-extended only in the two signed interpretations.
  function automatic logic mode_is_signed(mul_mode_e m);
    return (m == MODE_SINT) || (m == MODE_QFRAC);
  endfunction

endpackage

// File: rtl/fxp_mul_prod.sv
module fxp_mul_prod #(
  parameter int N = 16
) (
  input  logic [N-1:0]          a,
  input  logic [N-1:0]          b,
  input  logic                  signed_en,
  output logic signed [2*N+1:0] prod
);
  localparam int EW = N + 1;

  logic signed [EW-1:0] ext_a;
  logic signed [EW-1:0] ext_b;

  // One extra top bit gives a single signed multiplier for both readings.
  always_comb begin
    ext_a = {signed_en & a[N-1], a};
    ext_b = {signed_en & b[N-1], b};
  end

  assign prod = ext_a * ext_b;

endmodule

// File: rtl/fxp_mul_pick.sv
module fxp_mul_pick
  import fxp_mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic signed [2*N+1:0] prod,
  input  mul_mode_e             mode,
  output logic [N-1:0]          res,
  output logic                  sat,
  output logic                  ovf_hi,
  output logic                  ovf_lo
);
  localparam int PW       = 2 * N + 2;
  localparam int INT_LSB  = N - 1;
  localparam int FRAC_LSB = N - 1;
  localparam int FRAC_TOP = 2 * N - 2;
  localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};

  // A signed value fits when every bit from position k upward equals the sign.
  function automatic logic fits_from(input logic signed [PW-1:0] p, input int k);
    logic signed [PW-1:0] sh;
    sh = p >>> k;
    return (sh == '0) || (sh == '1);
  endfunction

  function automatic logic upper_clear(input logic signed [PW-1:0] p);
    logic [PW-1:0] u;
    u = p;
    return (u >> N) == '0;
  endfunction

  logic fit_uint, fit_sint, fit_frac;

  always_comb begin
    fit_uint = upper_clear(prod);
    fit_sint = fits_from(prod, INT_LSB);
    fit_frac = fits_from(prod, FRAC_TOP);
  end

  always_comb begin
    res    = '0;
    sat    = 1'b0;
    ovf_hi = 1'b0;
    ovf_lo = 1'b0;
    unique case (mode)
      MODE_SINT: begin
        if (fit_sint) begin
          res = prod[N-1:0];
        end else if (prod[PW-1]) begin
          ovf_lo = 1'b1;
          sat    = 1'b1;
          res    = SMIN;
        end else begin
          ovf_hi = 1'b1;
          sat    = 1'b1;
          res    = SMAX;
        end
      end
      MODE_QFRAC: begin
        if (fit_frac) begin
          res = prod[FRAC_TOP:FRAC_LSB];
        end else if (prod[PW-1]) begin
          ovf_lo = 1'b1;
          sat    = 1'b1;
          res    = SMIN;
        end else begin
          ovf_hi = 1'b1;
          sat    = 1'b1;
          res    = SMAX;
        end
      end
      default: begin
        if (fit_uint) begin
          res = prod[N-1:0];
        end else begin
          ovf_hi = 1'b1;
          sat    = 1'b1;
          res    = '1;
        end
      end
    endcase
  end

endmodule

// File: rtl/fxp_sat_mul.sv
module fxp_sat_mul
  import fxp_mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [1:0]   mode,
  output logic         out_valid,
  output logic [N-1:0] out_res,
  output logic         out_sat
);
  mul_mode_e             mode_e;
  logic                  signed_en;
  logic signed [2*N+1:0] full_prod;
  logic [N-1:0]          pick_res;
  logic                  pick_sat;
  logic                  sel_ovf_hi;
  logic                  sel_ovf_lo;

  assign mode_e    = mul_mode_e'(mode);
  assign signed_en = mode_is_signed(mode_e);

  fxp_mul_prod #(.N(N)) u_prod (
    .a         (op_a),
    .b         (op_b),
    .signed_en (signed_en),
    .prod      (full_prod)
  );

  fxp_mul_pick #(.N(N)) u_pick (
    .prod   (full_prod),
    .mode   (mode_e),
    .res    (pick_res),
    .sat    (pick_sat),
    .ovf_hi (sel_ovf_hi),
    .ovf_lo (sel_ovf_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res <= pick_res;
        out_sat <= pick_sat;
      end
    end
  end

endmodule

// File: rtl/fxp_sat_mul_chk.sv
module fxp_sat_mul_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic [1:0]   mode,
  input logic         out_valid,
  input logic [N-1:0] out_res,
  input logic         out_sat,
  input logic         ovf_hi,
  input logic         ovf_lo
);
  localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_res) && $stable(out_sat)));  // R9
  AST_UINT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 2'b00 || mode == 2'b11)) |=> (!out_sat || (&out_res)));  // R2
  AST_SINT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> (!out_sat || out_res == SMAX || out_res == SMIN));  // R4
  AST_FRAC_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> (out_sat == ($past(op_a) == SMIN && $past(op_b) == SMIN)));  // R6
  AST_FRAC_CORNER_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && op_a == SMIN && op_b == SMIN) |=> (out_res == SMAX));  // R6
  AST_NO_SPURIOUS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf_hi && !ovf_lo) |=> !out_sat);  // R7
  AST_OVF_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_hi && ovf_lo));  // R4

endmodule

bind fxp_sat_mul fxp_sat_mul_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .mode      (mode),
  .out_valid (out_valid),
  .out_res   (out_res),
  .out_sat   (out_sat),
  .ovf_hi    (sel_ovf_hi),
  .ovf_lo    (sel_ovf_lo)
);

// File: tb/fxp_sat_mul_test.sv
`timescale 1ns/1ps
module fxp_sat_mul_test;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        v16 = 1'b0, v4 = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [1:0]  m16 = '0, m4 = '0;
  logic        ov16, ov4, os16, os4;
  logic [15:0] or16;
  logic [3:0]  or4;

  fxp_sat_mul #(.N(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v16), .op_a(a16), .op_b(b16), .mode(m16),
    .out_valid(ov16), .out_res(or16), .out_sat(os16));

  fxp_sat_mul #(.N(4)) uut_n4 (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .op_a(a4), .op_b(b4), .mode(m4),
    .out_valid(ov4), .out_res(or4), .out_sat(os4));

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 0;

  // Behavioural reference: exact integer product, then the mode's rule.
  function automatic void ref_mul(input int w, input longint ua, input longint ub,
                                  input int md, output longint res, output bit sat);
    longint sa, sb, p, q, mx, mn, umax;
    umax = (longint'(1) << w) - 1;
    mx   = (longint'(1) << (w - 1)) - 1;
    mn   = -(longint'(1) << (w - 1));
    sa   = (ua > mx) ? ua - (longint'(1) << w) : ua;
    sb   = (ub > mx) ? ub - (longint'(1) << w) : ub;
    sat  = 0;
    if (md == 1) begin
      p = sa * sb;
      if (p > mx) begin q = mx; sat = 1; end
      else if (p < mn) begin q = mn; sat = 1; end
      else q = p;
    end else if (md == 2) begin
      p = sa * sb;
      q = p >>> (w - 1);
      if (q > mx) begin q = mx; sat = 1; end
    end else begin
      p = ua * ub;
      if (p > umax) begin q = umax; sat = 1; end
      else q = p;
    end
    res = q & umax;
  endfunction

  function automatic string tag_of(input int md, input bit sat);
    if (md == 3) return "R10";
    if (md == 0) return sat ? "R2" : "R1";
    if (md == 1) return sat ? "R4" : "R3";
    return sat ? "R6" : "R5";
  endfunction

  longint e16_res = 0, e4_res = 0;
  bit     e16_sat = 0, e4_sat = 0, e16_vld = 0, e4_vld = 0;
  string  t16 = "R11", t4 = "R11", s16 = "R11", s4 = "R11";

  always @(posedge clk) begin
    longint r;
    bit s;
    if (!rst_n) begin
      e16_res = 0; e16_sat = 0; e16_vld = 0; t16 = "R11"; s16 = "R11";
      e4_res = 0;  e4_sat = 0;  e4_vld = 0;  t4 = "R11";  s4 = "R11";
    end else begin
      e16_vld = v16;
      if (v16) begin
        ref_mul(16, longint'(a16), longint'(b16), int'(m16), r, s);
        e16_res = r; e16_sat = s;
        t16 = tag_of(int'(m16), s);
        s16 = s ? t16 : "R7";
      end else begin
        t16 = "R9"; s16 = "R9";
      end
      e4_vld = v4;
      if (v4) begin
        ref_mul(4, longint'(a4), longint'(b4), int'(m4), r, s);
        e4_res = r; e4_sat = s;
        t4 = tag_of(int'(m4), s);
        s4 = s ? t4 : "R7";
      end else begin
        t4 = "R9"; s4 = "R9";
      end
    end
    started = 1;
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare at the falling edge, half a period after the registers move.
  always @(negedge clk) begin
    if (started) begin
      check("R8", "out_valid n16", longint'(ov16), longint'(e16_vld));
      check(t16,  "out_res n16",   longint'(or16), e16_res);
      check(s16,  "out_sat n16",   longint'(os16), longint'(e16_sat));
      check("R8", "out_valid n4",  longint'(ov4),  longint'(e4_vld));
      check(t4,   "out_res n4",    longint'(or4),  e4_res);
      check(s4,   "out_sat n4",    longint'(os4),  longint'(e4_sat));
    end
  end

  task automatic step(input bit va, input logic [15:0] x, input logic [15:0] y, input logic [1:0] m,
                      input bit vb, input logic [3:0] p, input logic [3:0] q, input logic [1:0] n);
    @(negedge clk);
    v16 = va; a16 = x; b16 = y; m16 = m;
    v4  = vb; a4  = p; b4  = q; m4  = n;
  endtask

  bit done = 0;

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;   // R11: outputs must read zero throughout reset
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // Directed corners (16-bit lane / 4-bit lane)
    step(1, 16'h0011, 16'hFE12, 2'b10, 1, 4'd3, 4'd8, 2'b00);   // R5 / R2
    step(1, 16'h7FFF, 16'h7FFF, 2'b10, 1, 4'd3, 4'h8, 2'b01);   // R5 / R4 low side
    step(1, 16'h8000, 16'h8000, 2'b10, 1, 4'h6, 4'hE, 2'b10);   // R6 / R5
    step(1, 16'h8000, 16'h7FFF, 2'b10, 1, 4'h8, 4'h8, 2'b10);   // R5 / R6
    step(0, 16'h1234, 16'h5678, 2'b00, 0, 4'h1, 4'h1, 2'b00);   // R9 hold
    step(0, 16'hFFFF, 16'hFFFF, 2'b01, 0, 4'hF, 4'hF, 2'b01);   // R9 hold
    step(1, 16'd300,  16'd200,  2'b00, 1, 4'd7, 4'd7, 2'b01);   // R1 / R4 high side
    step(1, 16'd256,  16'd256,  2'b00, 1, 4'h8, 4'h8, 2'b01);   // R2 / R4
    step(1, 16'd256,  16'd256,  2'b11, 1, 4'd3, 4'd5, 2'b11);   // R10
    step(1, 16'h8000, 16'hFFFF, 2'b01, 1, 4'hE, 4'd3, 2'b01);   // R4 / R3
    step(1, 16'hFF38, 16'd100,  2'b01, 1, 4'd3, 4'd5, 2'b00);   // R3 / R1
    step(1, 16'h8000, 16'd2,    2'b01, 1, 4'h9, 4'h7, 2'b10);   // R4 / R5
    step(0, 16'h0,    16'h0,    2'b00, 0, 4'h0, 4'h0, 2'b00);   // R8 idle
    // Mixed random traffic in all modes
    for (int i = 0; i < 400; i++) begin
      step(bit'($urandom_range(0, 3) != 0), 16'($urandom), 16'($urandom), 2'($urandom),
           bit'($urandom_range(0, 3) != 0), 4'($urandom), 4'($urandom), 2'($urandom));
    end
    step(0, 16'h0, 16'h0, 2'b00, 0, 4'h0, 4'h0, 2'b00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule